// File: doc/BRIEF.md
# Single-Issue Core Memory Request Sequencer

This block is the control sequencer of a simple in-order core that keeps at most one memory transaction in flight. It runs the loop fetch, execute, optional data access, fetch again over two request ports, one for instruction fetch and one for data. Each port has a request/accept handshake, a retry strobe, and a response that can come back negatively acknowledged. Decode, execution, caches and address translation are outside the block. Stub inputs that come with each fetch response stand in for them: memory op, store, locked and delayed-commit. A separate translation-fault flag is sampled when a fetch is attempted.

A refused request stays in the port's holding register until that port strobes retry, and is then offered again unchanged. A negatively acknowledged response makes the port offer the same request again on the next cycle. Control inputs cover the rest of the core's life: activation after a programmable delay, suspension, switching the core out and back in, a drain request that quiesces the core, and a resume that restarts fetching after a drain. A counter reports elapsed active cycles at each fetch offer and each completed response.

Top module: `core_access_seq`

## Requirements
- R1: After reset the sequencer is idle. No request is offered on either port, drain_ack and irq_check are 0, cycle_count is 0, and no fetch starts until activate.
- R2: A request offered while the port's accept is low is withdrawn (valid low on the next cycle) and held. A retry strobe then makes the port offer the identical address or command again on the next cycle. A retry is legal only while that port is in its retry state.
- R3: A response with its nack bit set makes the port offer the same request again on the next cycle. Responses are legal only while the port waits with no request on offer.
- R4: Activate, legal only when idle, makes the first fetch appear act_delay+1 cycles after the activate edge. Suspend, legal only while running, stops any pending fetch.
- R5: A fetch response for a non-memory instruction completes it, and the next fetch is offered on the following cycle at the previous address plus ISTEP.
- R6: A memory instruction's data request is offered in the cycle after its fetch response, with d_req_cmd = {lock, store}: 0 read, 1 write, 2 load-locked, 3 store-conditional.
- R7: A locked store with sc_suppress high completes with no data request, and the next fetch follows at the next address.
- R8: When fetch_fault is high at a fetch attempt, no fetch is offered, and the next fetch goes to FAULT_PC.
- R9: drain_req while idle, running or switched out raises drain_ack for one cycle on the next cycle and cancels any pending fetch. resume then restarts fetching on the following cycle.
- R10: drain_req while a fetch is outstanding is acknowledged when that fetch response arrives. The instruction is discarded and no data request is made. After resume, the same address is fetched again.
- R11: drain_req while a data access is outstanding is acknowledged on the data response. The instruction completes, the address advances, and no new fetch starts until resume.
- R12: irq_check pulses with each fetch attempt unless the last executed instruction had the delayed-commit flag.
- R13: At each fetch offer and each completed response, cycle_count loads the number of clock edges since reset that were not spent switched out. switch_out and take_over move between idle and the switched-out state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst | input | 1 | synchronous active-high reset |
| activate | input | 1 | start the core from idle |
| act_delay | input | DLYW | cycles to wait before the first fetch |
| suspend | input | 1 | stop fetching and go idle |
| resume | input | 1 | restart fetching after a drain |
| switch_out | input | 1 | park the core (from idle or running) |
| take_over | input | 1 | return a parked core to idle |
| drain_req | input | 1 | request quiescence |
| drain_ack | output | 1 | one-cycle drain grant |
| irq_check | output | 1 | interrupt poll strobe at a fetch attempt |
| fetch_fault | input | 1 | fetch address translation faults |
| f_req_valid | output | 1 | fetch request on offer |
| f_req_addr | output | AW | fetch address |
| f_accept | input | 1 | fetch port takes the offered request |
| f_retry | input | 1 | fetch port can now take the held request |
| f_resp_valid | input | 1 | fetch response |
| f_resp_nack | input | 1 | fetch response is a negative acknowledge |
| f_resp_mem | input | 1 | fetched instruction accesses memory |
| f_resp_store | input | 1 | fetched instruction is a store |
| f_resp_lock | input | 1 | fetched instruction is locked |
| f_resp_dc | input | 1 | fetched instruction is delayed-commit |
| sc_suppress | input | 1 | locked store is suppressed |
| d_req_valid | output | 1 | data request on offer |
| d_req_cmd | output | 2 | data command |
| d_accept | input | 1 | data port takes the offered request |
| d_retry | input | 1 | data port can now take the held request |
| d_resp_valid | input | 1 | data response |
| d_resp_nack | input | 1 | data response is a negative acknowledge |
| cycle_count | output | CNTW | active cycles at the last event |

## Verification
A table of eight instruction patterns is run back to back: a plain operation, a load, a store, a locked load, a store-conditional, a suppressed store-conditional, a faulting fetch and a plain operation with a refused fetch. Some patterns add a refusal or a nack on the port that carries them. The patterns separate the four command encodings and the two paths with no data request. They also distinguish withdraw-and-hold from reissue, and the fault redirect from the ordinary address step. Directed sequences then place a drain request in each of the three waiting situations: idle or running, outstanding fetch, and outstanding data access. This shows whether the instruction is discarded or completed and where fetching resumes. Other directed sequences measure the activate delay, show that the delayed-commit flag masks the interrupt poll, and show that switched-out time is left out of the cycle count.

// File: rtl/cas_pkg.sv
package cas_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_RUN, S_F_RETRY, S_F_WAIT, S_D_RETRY, S_D_WAIT, S_SWOUT
  } seq_state_t;

  typedef enum logic [1:0] {
    C_READ = 2'd0, C_WRITE = 2'd1, C_LLOAD = 2'd2, C_SCOND = 2'd3
  } dcmd_t;
endpackage

// File: rtl/cas_req_port.sv
// One request port: offers a request for one cycle, keeps it when refused,
// re-offers on retry (in retry state) or on a negatively acknowledged response.
module cas_req_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         issue,
  input  logic [W-1:0] issue_data,
  input  logic         accept,
  input  logic         retry,
  input  logic         in_retry,
  input  logic         resp_nack,
  output logic         req_valid,
  output logic [W-1:0] req_data,
  output logic         refused
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_data  <= '0;
    end else if (issue) begin
      req_valid <= 1'b1;
      req_data  <= issue_data;
    end else if (req_valid) begin
      req_valid <= 1'b0;
    end else if ((retry && in_retry) || resp_nack) begin
      req_valid <= 1'b1;
    end
  end

  assign refused = req_valid && !accept;

  // R2: retry strobes only arrive while the request is held
  a_r2_retry_legal: assert property (@(posedge clk) disable iff (rst)
    retry |-> in_retry);
  // R2: a refused offer is withdrawn on the next cycle
  a_r2_refused_withdrawn: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !accept) |=> !req_valid);
  // R3: a nack brings back the very same request
  a_r3_nack_reoffer: assert property (@(posedge clk) disable iff (rst)
    resp_nack |=> (req_valid && $stable(req_data)));
endmodule

// File: rtl/cas_cycle_meter.sv
// Active-cycle meter: counts edges outside the parked state and publishes
// the running total at each marked event.
module cas_cycle_meter #(
  parameter int CNTW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            mark,
  output logic [CNTW-1:0] total
);
  logic [CNTW-1:0] live;
  logic [CNTW-1:0] live_n;

  assign live_n = run ? live + 1'b1 : live;

  always_ff @(posedge clk) begin
    if (rst) begin
      live  <= '0;
      total <= '0;
    end else begin
      live <= live_n;
      if (mark) total <= live_n;
    end
  end

  // R13: published count never goes backwards
  a_r13_monotonic: assert property (@(posedge clk) disable iff (rst)
    total >= $past(total));
endmodule

// File: rtl/core_access_seq.sv
module core_access_seq
  import cas_pkg::*;
#(
  parameter int              AW       = 32,
  parameter int              DLYW     = 8,
  parameter int              CNTW     = 32,
  parameter logic [AW-1:0]   BOOT_PC  = '0,
  parameter logic [AW-1:0]   FAULT_PC = 'h100,
  parameter logic [AW-1:0]   ISTEP    = 'd4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            activate,
  input  logic [DLYW-1:0] act_delay,
  input  logic            suspend,
  input  logic            resume,
  input  logic            switch_out,
  input  logic            take_over,
  input  logic            drain_req,
  output logic            drain_ack,
  output logic            irq_check,
  input  logic            fetch_fault,
  output logic            f_req_valid,
  output logic [AW-1:0]   f_req_addr,
  input  logic            f_accept,
  input  logic            f_retry,
  input  logic            f_resp_valid,
  input  logic            f_resp_nack,
  input  logic            f_resp_mem,
  input  logic            f_resp_store,
  input  logic            f_resp_lock,
  input  logic            f_resp_dc,
  input  logic            sc_suppress,
  output logic            d_req_valid,
  output logic [1:0]      d_req_cmd,
  input  logic            d_accept,
  input  logic            d_retry,
  input  logic            d_resp_valid,
  input  logic            d_resp_nack,
  output logic [CNTW-1:0] cycle_count
);
  seq_state_t      st, st_n;
  logic [AW-1:0]   pc, pc_n;
  logic [DLYW-1:0] cnt, cnt_n;
  logic            pend, pend_n;
  logic            draining, drn_n;
  logic            last_dc, dc_n;
  logic            ack_n, irq_n;
  logic            f_issue, d_issue, mark;
  logic [1:0]      d_cmd_n;
  logic            f_refused, d_refused;
  logic            f_ok, d_ok, drn_now;

  assign f_ok    = (st == S_F_WAIT) && f_resp_valid && !f_resp_nack;
  assign d_ok    = (st == S_D_WAIT) && d_resp_valid && !d_resp_nack;
  assign drn_now = draining || drain_req;
  assign d_cmd_n = {f_resp_lock, f_resp_store};

  always_comb begin
    st_n = st;  pc_n = pc;  cnt_n = cnt;  pend_n = pend;
    drn_n = draining;  dc_n = last_dc;
    ack_n = 1'b0;  irq_n = 1'b0;
    f_issue = 1'b0;  d_issue = 1'b0;  mark = 1'b0;
    case (st)
      S_IDLE: begin
        if (drain_req) ack_n = 1'b1;
        else if (activate) begin
          st_n = S_RUN;  pend_n = 1'b1;  cnt_n = act_delay;
        end else if (switch_out) st_n = S_SWOUT;
      end
      S_RUN: begin
        if (drain_req) begin
          ack_n = 1'b1;  pend_n = 1'b0;
        end else if (suspend) begin
          st_n = S_IDLE;  pend_n = 1'b0;
        end else if (switch_out) begin
          st_n = S_SWOUT;  pend_n = 1'b0;
        end else if (resume) begin
          pend_n = 1'b1;  cnt_n = '0;
        end else if (pend) begin
          if (cnt != '0) cnt_n = cnt - 1'b1;
          else begin
            irq_n = !last_dc;
            if (fetch_fault) pc_n = FAULT_PC;
            else begin
              f_issue = 1'b1;  mark = 1'b1;  pend_n = 1'b0;  st_n = S_F_WAIT;
            end
          end
        end
      end
      S_F_WAIT: begin
        if (drain_req) drn_n = 1'b1;
        if (f_refused) st_n = S_F_RETRY;
        else if (f_ok) begin
          mark = 1'b1;  st_n = S_RUN;
          if (drn_now) begin
            ack_n = 1'b1;  drn_n = 1'b0;  pend_n = 1'b0;
          end else begin
            dc_n = f_resp_dc;
            if (!f_resp_mem || (f_resp_lock && f_resp_store && sc_suppress)) begin
              pc_n = pc + ISTEP;  pend_n = 1'b1;  cnt_n = '0;
            end else begin
              d_issue = 1'b1;  st_n = S_D_WAIT;
            end
          end
        end
      end
      S_F_RETRY: begin
        if (drain_req) drn_n = 1'b1;
        if (f_retry) st_n = S_F_WAIT;
      end
      S_D_WAIT: begin
        if (drain_req) drn_n = 1'b1;
        if (d_refused) st_n = S_D_RETRY;
        else if (d_ok) begin
          mark = 1'b1;  st_n = S_RUN;  pc_n = pc + ISTEP;
          if (drn_now) begin
            ack_n = 1'b1;  drn_n = 1'b0;  pend_n = 1'b0;
          end else begin
            pend_n = 1'b1;  cnt_n = '0;
          end
        end
      end
      S_D_RETRY: begin
        if (drain_req) drn_n = 1'b1;
        if (d_retry) st_n = S_D_WAIT;
      end
      S_SWOUT: begin
        if (drain_req) ack_n = 1'b1;
        else if (take_over) st_n = S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;  pc <= BOOT_PC;  cnt <= '0;  pend <= 1'b0;
      draining <= 1'b0;  last_dc <= 1'b0;
      drain_ack <= 1'b0;  irq_check <= 1'b0;
    end else begin
      st <= st_n;  pc <= pc_n;  cnt <= cnt_n;  pend <= pend_n;
      draining <= drn_n;  last_dc <= dc_n;
      drain_ack <= ack_n;  irq_check <= irq_n;
    end
  end

  cas_req_port #(.W(AW)) u_fport (
    .clk(clk), .rst(rst), .issue(f_issue), .issue_data(pc),
    .accept(f_accept), .retry(f_retry), .in_retry(st == S_F_RETRY),
    .resp_nack((st == S_F_WAIT) && f_resp_valid && f_resp_nack),
    .req_valid(f_req_valid), .req_data(f_req_addr), .refused(f_refused)
  );

  cas_req_port #(.W(2)) u_dport (
    .clk(clk), .rst(rst), .issue(d_issue), .issue_data(d_cmd_n),
    .accept(d_accept), .retry(d_retry), .in_retry(st == S_D_RETRY),
    .resp_nack((st == S_D_WAIT) && d_resp_valid && d_resp_nack),
    .req_valid(d_req_valid), .req_data(d_req_cmd), .refused(d_refused)
  );

  cas_cycle_meter #(.CNTW(CNTW)) u_meter (
    .clk(clk), .rst(rst), .run(st != S_SWOUT), .mark(mark), .total(cycle_count)
  );

  // R4: suspend only while running, activate only while idle
  a_r4_suspend_legal: assert property (@(posedge clk) disable iff (rst)
    suspend |-> (st == S_RUN));
  a_r4_activate_legal: assert property (@(posedge clk) disable iff (rst)
    activate |-> (st == S_IDLE));
  // R3: fetch responses only while waiting with nothing on offer
  a_r3_fresp_legal: assert property (@(posedge clk) disable iff (rst)
    f_resp_valid |-> (st == S_F_WAIT && !f_req_valid));
  // R8: a faulting attempt never produces a fetch offer
  a_r8_fault_no_offer: assert property (@(posedge clk) disable iff (rst)
    (st == S_RUN && fetch_fault) |=> !f_req_valid);
  // R9: a drain grant coincides with both ports quiet
  a_r9_drain_quiet: assert property (@(posedge clk) disable iff (rst)
    drain_ack |-> (!f_req_valid && !d_req_valid));
  // R2: one transaction at a time
  a_r2_single_offer: assert property (@(posedge clk) disable iff (rst)
    !(f_req_valid && d_req_valid));
endmodule

// File: tb/core_access_seq_test.sv
`timescale 1ns/1ps
module core_access_seq_test;
  localparam int AW = 32;
  localparam logic [AW-1:0] FAULT_PC = 'h100;

  logic clk = 0, rst = 1;
  logic activate = 0, suspend = 0, resume = 0, switch_out = 0, take_over = 0;
  logic drain_req = 0, fetch_fault = 0, sc_suppress = 0;
  logic [7:0] act_delay = 0;
  logic f_accept = 1, f_retry = 0, f_resp_valid = 0, f_resp_nack = 0;
  logic f_resp_mem = 0, f_resp_store = 0, f_resp_lock = 0, f_resp_dc = 0;
  logic d_accept = 1, d_retry = 0, d_resp_valid = 0, d_resp_nack = 0;
  logic drain_ack, irq_check, f_req_valid, d_req_valid;
  logic [AW-1:0] f_req_addr;
  logic [1:0] d_req_cmd;
  logic [31:0] cycle_count;

  int nchk = 0, nbad = 0;
  longint ecount = 0;
  bit done = 0;
  logic [AW-1:0] exp_pc = '0;

  always #5 clk = ~clk;
  always @(posedge clk) if (!rst) ecount <= ecount + 1;

  core_access_seq uut (
    .clk(clk), .rst(rst), .activate(activate), .act_delay(act_delay),
    .suspend(suspend), .resume(resume), .switch_out(switch_out),
    .take_over(take_over), .drain_req(drain_req), .drain_ack(drain_ack),
    .irq_check(irq_check), .fetch_fault(fetch_fault),
    .f_req_valid(f_req_valid), .f_req_addr(f_req_addr), .f_accept(f_accept),
    .f_retry(f_retry), .f_resp_valid(f_resp_valid), .f_resp_nack(f_resp_nack),
    .f_resp_mem(f_resp_mem), .f_resp_store(f_resp_store),
    .f_resp_lock(f_resp_lock), .f_resp_dc(f_resp_dc), .sc_suppress(sc_suppress),
    .d_req_valid(d_req_valid), .d_req_cmd(d_req_cmd), .d_accept(d_accept),
    .d_retry(d_retry), .d_resp_valid(d_resp_valid), .d_resp_nack(d_resp_nack),
    .cycle_count(cycle_count)
  );

  // [8]fault [7]refuse [6]nack [5]mem [4]store [3]lock [2]suppress [1:0]expected cmd
  localparam logic [8:0] VEC [0:7] = '{
    9'b0_0_1_0_0_0_0_00,  // plain op, fetch nacked
    9'b0_0_0_1_0_0_0_00,  // load
    9'b0_1_0_1_1_0_0_01,  // store, data refused
    9'b0_0_1_1_0_1_0_10,  // locked load, data nacked
    9'b0_0_0_1_1_1_0_11,  // store-conditional
    9'b0_0_0_1_1_1_1_11,  // suppressed store-conditional
    9'b1_0_0_0_0_0_0_00,  // faulting fetch
    9'b0_1_0_0_0_0_0_00   // plain op, fetch refused
  };

  task automatic tick; @(negedge clk); endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_f(output int n);
    n = 0;
    while (!f_req_valid && n < 40) begin tick(); n++; end
  endtask

  task automatic quiet(input int k, input string tag);
    bit seen = 0;
    repeat (k) begin tick(); if (f_req_valid || d_req_valid) seen = 1; end
    chk(!seen, tag, seen, 0);
  endtask

  task automatic give_f(input bit refuse);
    if (refuse) begin
      f_accept = 0; tick(); f_accept = 1;
      chk(!f_req_valid, "R2 fetch withdrawn", f_req_valid, 0);
      f_retry = 1; tick(); f_retry = 0;
      chk(f_req_valid && f_req_addr == exp_pc, "R2 fetch resent", f_req_addr, exp_pc);
    end
    tick();
  endtask

  task automatic give_d(input bit refuse, input logic [1:0] cmd);
    if (refuse) begin
      d_accept = 0; tick(); d_accept = 1;
      chk(!d_req_valid, "R2 data withdrawn", d_req_valid, 0);
      d_retry = 1; tick(); d_retry = 0;
      chk(d_req_valid && d_req_cmd == cmd, "R2 data resent", d_req_cmd, cmd);
    end
    tick();
  endtask

  task automatic resp_f(input bit nack, input bit mem, input bit st, input bit lk,
                        input bit dc, input bit sup);
    f_resp_mem = mem; f_resp_store = st; f_resp_lock = lk; f_resp_dc = dc; sc_suppress = sup;
    if (nack) begin
      f_resp_valid = 1; f_resp_nack = 1; tick(); f_resp_valid = 0; f_resp_nack = 0;
      chk(f_req_valid && f_req_addr == exp_pc, "R3 fetch reissued", f_req_addr, exp_pc);
      tick();
    end
    f_resp_valid = 1; tick(); f_resp_valid = 0;
  endtask

  task automatic resp_d(input bit nack, input logic [1:0] cmd);
    if (nack) begin
      d_resp_valid = 1; d_resp_nack = 1; tick(); d_resp_valid = 0; d_resp_nack = 0;
      chk(d_req_valid && d_req_cmd == cmd, "R3 data reissued", d_req_cmd, cmd);
      tick();
    end
    d_resp_valid = 1; tick(); d_resp_valid = 0;
  endtask

  task automatic plain(input bit dc);
    int n;
    wait_f(n);
    chk(f_req_addr == exp_pc, "R5 fetch address", f_req_addr, exp_pc);
    give_f(0);
    resp_f(0, 0, 0, 0, dc, 0);
    exp_pc = exp_pc + 4;
  endtask

  task automatic finish_run;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int n;
    repeat (3) tick();
    rst = 0;
    // R1: reset state
    chk(!f_req_valid && !d_req_valid && !drain_ack && !irq_check, "R1 outputs idle", f_req_valid, 0);
    chk(cycle_count == 0, "R1 counter clear", cycle_count, 0);
    quiet(4, "R1 no fetch before activate");

    // R13/R9: park the core, drain while parked, return
    switch_out = 1; tick(); switch_out = 0;
    drain_req = 1; tick(); drain_req = 0;
    chk(drain_ack == 1, "R9 drain while switched out", drain_ack, 1);
    repeat (5) tick();
    take_over = 1; tick(); take_over = 0;

    // R4: activate with delay 2
    act_delay = 2; activate = 1; tick(); activate = 0;
    wait_f(n);
    chk(n == 3, "R4 activate delay", n, 3);
    chk(f_req_addr == exp_pc && irq_check, "R12 first fetch polls", irq_check, 1);
    chk(cycle_count == ecount - 7, "R13 parked time excluded", cycle_count, ecount - 7);
    give_f(0);
    resp_f(0, 0, 0, 0, 0, 0);
    exp_pc = exp_pc + 4;

    // table walk
    for (int i = 0; i < 8; i++) begin
      logic [8:0] v;
      bit expd;
      v = VEC[i];
      if (v[8]) begin
        fetch_fault = 1; tick(); fetch_fault = 0;
        exp_pc = FAULT_PC;
      end
      wait_f(n);
      chk(f_req_valid && f_req_addr == exp_pc, v[8] ? "R8 fault redirect" : "R5 fetch address",
          f_req_addr, exp_pc);
      chk(irq_check == 1, "R12 poll at fetch", irq_check, 1);
      give_f(!v[5] && v[7]);
      resp_f(!v[5] && v[6], v[5], v[4], v[3], 0, v[2]);
      expd = v[5] && !(v[4] && v[3] && v[2]);
      chk(d_req_valid == expd, expd ? "R6 data offered" : "R7 no data request", d_req_valid, expd);
      if (expd) begin
        chk(d_req_cmd == v[1:0], "R6 command encoding", d_req_cmd, v[1:0]);
        give_d(v[7], v[1:0]);
        resp_d(v[6], v[1:0]);
      end
      exp_pc = exp_pc + 4;
    end

    // R4: suspend then reactivate with delay 4
    suspend = 1; tick(); suspend = 0;
    quiet(5, "R4 suspend stops fetch");
    act_delay = 4; activate = 1; tick(); activate = 0;
    wait_f(n);
    chk(n == 5 && f_req_addr == exp_pc, "R4 delayed restart", n, 5);
    give_f(0);
    resp_f(0, 0, 0, 0, 1, 0);
    exp_pc = exp_pc + 4;
    wait_f(n);
    chk(irq_check == 0, "R12 delayed-commit masks poll", irq_check, 0);
    give_f(0);
    resp_f(0, 0, 0, 0, 0, 0);
    exp_pc = exp_pc + 4;

    // R9: drain while running
    drain_req = 1; tick(); drain_req = 0;
    chk(drain_ack == 1 && !f_req_valid, "R9 immediate drain", drain_ack, 1);
    quiet(4, "R9 quiet after drain");
    resume = 1; tick(); resume = 0;
    wait_f(n);
    chk(n == 1 && f_req_addr == exp_pc, "R9 resume refetch", n, 1);

    // R10: drain with fetch outstanding
    give_f(0);
    drain_req = 1; tick(); drain_req = 0;
    chk(drain_ack == 0, "R10 no early grant", drain_ack, 0);
    resp_f(0, 1, 0, 0, 0, 0);
    chk(drain_ack == 1 && !d_req_valid, "R10 grant on fetch response", drain_ack, 1);
    quiet(4, "R10 instruction discarded");
    resume = 1; tick(); resume = 0;
    wait_f(n);
    chk(f_req_addr == exp_pc, "R10 same address refetched", f_req_addr, exp_pc);

    // R11: drain with data outstanding
    give_f(0);
    resp_f(0, 1, 0, 0, 0, 0);
    chk(d_req_valid && d_req_cmd == 2'd0, "R6 load command", d_req_cmd, 0);
    give_d(0, 2'd0);
    drain_req = 1; tick(); drain_req = 0;
    chk(drain_ack == 0, "R11 no early grant", drain_ack, 0);
    resp_d(0, 2'd0);
    chk(drain_ack == 1, "R11 grant on data response", drain_ack, 1);
    exp_pc = exp_pc + 4;
    quiet(4, "R11 no fetch until resume");
    resume = 1; tick(); resume = 0;
    wait_f(n);
    chk(f_req_addr == exp_pc, "R11 address advanced", f_req_addr, exp_pc);
    give_f(0);
    resp_f(0, 0, 0, 0, 0, 0);
    exp_pc = exp_pc + 4;
    plain(0);

    repeat (2) tick();
    finish_run();
  end
endmodule